// File: doc/BRIEF.md
# Protected Serial Control Register

This block holds one control byte behind a two-wire serial slave. It works on byte-level events: a bus front end reports start, stop, each received byte and each request for a byte to send. The block returns an acknowledge decision for every received byte and supplies the read byte on request. The register answers only to its own device-type preamble and to one fixed internal address. Its persistent fields change only through a guarded three-transaction sequence.

A write transaction carries a slave byte, an address byte and exactly one data byte. The data takes effect when the stop event arrives. The first two updates arm two volatile enable latches. The third stores the persistent fields and starts a store period. During that period the block reports busy and refuses its preamble. A read sets the address with a write header, restarts, sends a read slave byte and collects one byte.

Top module: `prot_ctrl_reg`

## Requirements
- R1: A slave byte (first byte after a start) is acknowledged only when its bits [7:4] are 1011b and busy is low. Bit 0 selects the direction (1 = read). Any other slave byte is not acknowledged, and the rest of that transaction is ignored and not acknowledged.
- R2: A write is addressed only when slave byte bit 1 is 1 (address bit 8) and the following address byte is FFh. Otherwise the address byte and all later bytes of the transaction are not acknowledged.
- R3: In an addressed write, the first data byte is acknowledged. Every further data byte is not acknowledged and is discarded.
- R4: A committed data byte 02h with the write-enable latch (bit 1) clear sets that latch. A committed 06h with bit 1 set and the register-enable latch (bit 2) clear sets bit 2. Bit 2 is never set while bit 1 is clear.
- R5: A committed data byte with both latches set stores data bits 7, 6, 5, 4, 3 and 0 into the persistent fields, and clears both latches.
- R6: A committed data byte that does not match the current step of the enable sequence leaves the register unchanged.
- R7: Data takes effect only on a stop. A start that arrives before the stop discards the held byte.
- R8: A store holds busy high for exactly STORE_CYCLES cycles, starting the cycle after the stop. While busy is high, slave bytes are not acknowledged and the persistent fields do not change.
- R9: A read transaction returns the byte {bit7 PUP-high field, bits 6:5 timer field, bits 4:3 protect field, bit2 register-enable, bit1 write-enable, bit0 PUP-low field}. Only the first read request of a transaction returns data.
- R10: ackStrobe pulses in the cycle after each received byte. rdValid pulses in the cycle after an accepted read request.
- R11: After reset both latches are clear, the persistent fields equal NV_INIT, busy is low, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evStart | input | 1 | Start or repeated start seen on the bus |
| evStop | input | 1 | Stop seen on the bus |
| evByteValid | input | 1 | A received byte is present on evByte |
| evByte | input | 8 | Received byte |
| evReadReq | input | 1 | Front end requests a byte to transmit |
| ackStrobe | output | 1 | Acknowledge decision valid |
| ackOk | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rdValid | output | 1 | Read byte valid |
| rdData | output | 8 | Read byte |
| busy | output | 1 | Store period in progress |

## Verification
Every cycle, the assertions check these properties: the ack strobe follows each byte, extra data bytes are refused, slave bytes are refused while busy, the register-enable latch never stands without the write-enable latch, a store clears both latches, and the persistent fields are frozen while busy. Other behaviours show only in the bench's transaction scenarios. These are the full three-step enable order, ignored out-of-order writes, a restart discarding a held byte, the exact busy length, address mismatches and the read-back layout.

// File: rtl/scReg_pkg.sv
package scReg_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] PREAMBLE = 4'b1011;
  localparam logic [BYTE_W-1:0] ADDR_LO = 8'hFF;
  localparam logic [BYTE_W-1:0] KEY_WEL = 8'h02;
  localparam logic [BYTE_W-1:0] KEY_RWEL = 8'h06;

  typedef struct packed {
    logic capture;
    logic commit;
    logic readOut;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SLAVE, ST_ADDR, ST_DATA, ST_HELD, ST_EXTRA, ST_READ, ST_RDONE
  } busState_t;
endpackage

// File: rtl/scReg_ctrl.sv
module scReg_ctrl
  import scReg_pkg::*;
#(
  parameter int STORE_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              evByteValid,
  input  logic [BYTE_W-1:0] evByte,
  input  logic              evReadReq,
  input  logic              storeStart,
  output dpStrobe_t         strobe,
  output logic              ackStrobe,
  output logic              ackOk,
  output logic              busy
);
  localparam int CNT_W = $clog2(STORE_CYCLES + 1);

  busState_t state, nextState;
  logic addrHi, ackNext;
  logic [CNT_W-1:0] storeCnt;

  assign busy = (storeCnt != '0);

  always_comb begin
    nextState = state;
    strobe = '0;
    ackNext = 1'b0;
    if (evStart) begin
      nextState = ST_SLAVE;
    end else if (evStop) begin
      if (state == ST_HELD || state == ST_EXTRA) strobe.commit = 1'b1;
      nextState = ST_IDLE;
    end else if (evByteValid) begin
      case (state)
        ST_SLAVE: begin
          if (evByte[7:4] == PREAMBLE && !busy) begin
            ackNext = 1'b1;
            nextState = evByte[0] ? ST_READ : ST_ADDR;
          end else begin
            nextState = ST_IDLE;
          end
        end
        ST_ADDR: begin
          if (addrHi && evByte == ADDR_LO) begin
            ackNext = 1'b1;
            nextState = ST_DATA;
          end else begin
            nextState = ST_IDLE;
          end
        end
        ST_DATA: begin
          ackNext = 1'b1;
          strobe.capture = 1'b1;
          nextState = ST_HELD;
        end
        ST_HELD, ST_EXTRA: nextState = ST_EXTRA;
        default: nextState = state;
      endcase
    end else if (evReadReq && state == ST_READ) begin
      strobe.readOut = 1'b1;
      nextState = ST_RDONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      addrHi <= 1'b0;
      ackStrobe <= 1'b0;
      ackOk <= 1'b0;
      storeCnt <= '0;
    end else begin
      state <= nextState;
      if (evByteValid && state == ST_SLAVE) addrHi <= evByte[1];
      ackStrobe <= evByteValid;
      ackOk <= ackNext;
      if (storeStart) storeCnt <= CNT_W'(STORE_CYCLES);
      else if (busy) storeCnt <= storeCnt - 1'b1;
    end
  end

  // R10
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    evByteValid && !evStart && !evStop |=> ackStrobe);

  // R3
  extra_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    evByteValid && !evStart && !evStop && (state == ST_HELD || state == ST_EXTRA) |=> !ackOk);

  // R8
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    evByteValid && !evStart && !evStop && state == ST_SLAVE && busy |=> ackStrobe && !ackOk);
endmodule

// File: rtl/scReg_datapath.sv
module scReg_datapath
  import scReg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] NV_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] evByte,
  input  logic              busy,
  output logic              storeStart,
  output logic              rdValid,
  output logic [BYTE_W-1:0] rdData
);
  localparam logic [BYTE_W-1:0] NV_MASK = 8'b1111_1001;

  logic [BYTE_W-1:0] holdByte;
  logic [BYTE_W-1:0] nvBits;
  logic wel, rwel;
  logic [BYTE_W-1:0] viewByte;

  assign storeStart = strobe.commit && wel && rwel;
  assign viewByte = (nvBits & NV_MASK) | {5'b0, rwel, wel, 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte <= '0;
      nvBits <= NV_INIT & NV_MASK;
      wel <= 1'b0;
      rwel <= 1'b0;
      rdValid <= 1'b0;
      rdData <= '0;
    end else begin
      if (strobe.capture) holdByte <= evByte;
      if (strobe.commit) begin
        if (wel && rwel) begin
          nvBits <= holdByte & NV_MASK;
          wel <= 1'b0;
          rwel <= 1'b0;
        end else if (!wel && holdByte == KEY_WEL) begin
          wel <= 1'b1;
        end else if (wel && !rwel && holdByte == KEY_RWEL) begin
          rwel <= 1'b1;
        end
      end
      rdValid <= strobe.readOut;
      if (strobe.readOut) rdData <= viewByte;
    end
  end

  // R4
  rwel_needs_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    rwel |-> wel);

  // R5
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |=> !wel && !rwel);

  // R8
  nv_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(nvBits));
endmodule

// File: rtl/prot_ctrl_reg.sv
module prot_ctrl_reg
  import scReg_pkg::*;
#(
  parameter int STORE_CYCLES = 2000,
  parameter logic [7:0] NV_INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       evStart,
  input  logic       evStop,
  input  logic       evByteValid,
  input  logic [7:0] evByte,
  input  logic       evReadReq,
  output logic       ackStrobe,
  output logic       ackOk,
  output logic       rdValid,
  output logic [7:0] rdData,
  output logic       busy
);
  dpStrobe_t strobe;
  logic storeStart;

  scReg_ctrl #(.STORE_CYCLES(STORE_CYCLES)) ctrlInst (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
    .evByteValid(evByteValid), .evByte(evByte), .evReadReq(evReadReq),
    .storeStart(storeStart), .strobe(strobe), .ackStrobe(ackStrobe),
    .ackOk(ackOk), .busy(busy)
  );

  scReg_datapath #(.NV_INIT(NV_INIT)) dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evByte(evByte), .busy(busy),
    .storeStart(storeStart), .rdValid(rdValid), .rdData(rdData)
  );

  // R11
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !busy && !ackStrobe && !rdValid);
endmodule

// File: tb/prot_ctrl_reg_test.sv
module prot_ctrl_reg_test;
  localparam int STORE = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evStart = 1'b0, evStop = 1'b0, evByteValid = 1'b0, evReadReq = 1'b0;
  logic [7:0] evByte = '0;
  logic ackStrobe, ackOk, rdValid, busy;
  logic [7:0] rdData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int expKind[$];
  logic [7:0] expVal[$];
  string expTag[$];

  always #5 clk = ~clk;

  prot_ctrl_reg #(.STORE_CYCLES(STORE), .NV_INIT(8'h00)) uut (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
    .evByteValid(evByteValid), .evByte(evByte), .evReadReq(evReadReq),
    .ackStrobe(ackStrobe), .ackOk(ackOk), .rdValid(rdValid),
    .rdData(rdData), .busy(busy)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when the design produces a result
  always @(negedge clk) begin
    if (rstN && (ackStrobe || rdValid)) begin
      if (expKind.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected output actual=ack%0b/rd%0b expected=none", ackStrobe, rdValid);
      end else begin
        int k;
        logic [7:0] v;
        string t;
        k = expKind.pop_front(); v = expVal.pop_front(); t = expTag.pop_front();
        if (k == 0) check(t, {7'b0, ackStrobe ? ackOk : 1'bx}, {7'b0, v[0]});
        else begin
          check({t, " valid"}, {7'b0, rdValid}, 8'h01);
          check(t, rdData, v);
        end
      end
    end
  end

  task automatic doStart();
    @(negedge clk) evStart = 1'b1;
    @(negedge clk) evStart = 1'b0;
  endtask

  task automatic doStop();
    @(negedge clk) evStop = 1'b1;
    @(negedge clk) evStop = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string tag);
    expKind.push_back(0); expVal.push_back({7'b0, expAck}); expTag.push_back(tag);
    @(negedge clk) begin evByteValid = 1'b1; evByte = b; end
    @(negedge clk) evByteValid = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] exp, input string tag);
    doStart();
    sendByte(8'hB2, 1, tag);
    sendByte(8'hFF, 1, tag);
    doStart();
    sendByte(8'hB3, 1, tag);
    expKind.push_back(1); expVal.push_back(exp); expTag.push_back(tag);
    @(negedge clk) evReadReq = 1'b1;
    @(negedge clk) evReadReq = 1'b0;
    // R9: a second request in the same transaction returns nothing
    @(negedge clk) evReadReq = 1'b1;
    @(negedge clk) begin
      evReadReq = 1'b0;
      check("R9 second read", {7'b0, rdValid}, 8'h00);
    end
    doStop();
  endtask

  task automatic writeReg(input logic [7:0] d, input string tag);
    doStart();
    sendByte(8'hB2, 1, tag);
    sendByte(8'hFF, 1, tag);
    sendByte(d, 1, tag);
    doStop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 busy", {7'b0, busy}, 8'h00);
    check("R11 ack", {7'b0, ackStrobe}, 8'h00);
    check("R11 rd", {7'b0, rdValid}, 8'h00);
    rstN = 1'b1;
    readReg(8'h00, "R11 readback");

    // R1 wrong preamble
    doStart();
    sendByte(8'hA2, 0, "R1 bad preamble");
    sendByte(8'hFF, 0, "R1 rest ignored");
    doStop();

    // R6 data without enable latches
    writeReg(8'h55, "R6 unarmed write");
    readReg(8'h00, "R6 unchanged");

    // R2 address mismatches
    doStart();
    sendByte(8'hB2, 1, "R2 header");
    sendByte(8'hFE, 0, "R2 low addr");
    sendByte(8'h02, 0, "R2 data after miss");
    doStop();
    doStart();
    sendByte(8'hB0, 1, "R2 header hi0");
    sendByte(8'hFF, 0, "R2 addr bit8 clear");
    doStop();
    readReg(8'h00, "R2 unchanged");

    // R4 enable sequence, with an out-of-order step first
    writeReg(8'h06, "R6 rwel key first");
    readReg(8'h00, "R6 rwel needs wel");
    writeReg(8'h02, "R4 wel key");
    readReg(8'h02, "R4 wel set");
    writeReg(8'h06, "R4 rwel key");
    readReg(8'h06, "R4 rwel set");

    // R7 abort by restart before stop
    doStart();
    sendByte(8'hB2, 1, "R7 header");
    sendByte(8'hFF, 1, "R7 addr");
    sendByte(8'hA5, 1, "R7 data");
    readReg(8'h06, "R7 discarded");

    // R3 + R5 commit with extra byte
    doStart();
    sendByte(8'hB2, 1, "R3 header");
    sendByte(8'hFF, 1, "R3 addr");
    sendByte(8'hFF, 1, "R3 first data");
    sendByte(8'h33, 0, "R3 extra data");
    doStop();
    // R8 busy window
    check("R8 busy start", {7'b0, busy}, 8'h01);
    doStart();
    sendByte(8'hB3, 0, "R8 nack while busy");
    doStop();
    while (busy) @(negedge clk);
    readReg(8'hF9, "R5 stored fields");

    // R8 exact busy length with a second full sequence
    writeReg(8'h02, "R4 wel again");
    writeReg(8'h06, "R4 rwel again");
    writeReg(8'h28, "R5 second store");
    check("R8 busy first", {7'b0, busy}, 8'h01);
    repeat (STORE - 1) @(negedge clk);
    check("R8 busy last", {7'b0, busy}, 8'h01);
    @(negedge clk);
    check("R8 busy end", {7'b0, busy}, 8'h00);
    readReg(8'h28, "R5 second readback");

    repeat (3) @(negedge clk);
    if (expKind.size() != 0) begin
      checks++; fails++;
      $display("FAIL R10 missing outputs actual=%0d expected=0", expKind.size());
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule